// File: doc/BRIEF.md
# Handshake Clock-Domain Crossing Bridge

This block joins a memory-mapped master running on one clock to a memory-mapped slave running on a second clock that has no fixed relation to the first. It handles one single read or write at a time. When the master issues a transfer, the master side latches the address, the write data and the direction, and it holds the master stalled with a wait signal. It then raises a level request. A two-flop synchronizer carries that request into the slave clock domain.

The slave side sees the synchronized request and drives the read or write strobe toward the slave. It keeps the strobe up for as long as the slave stalls. When the slave accepts the access, the slave side registers any read data and raises a level acknowledge, which is synchronized back into the master domain. The master side then takes the read data, drops the request, and releases the master for exactly one cycle. Request and acknowledge form a four-phase handshake. A new transfer starts only after both have returned low, so every transfer costs a few cycles in each domain. Bursts and pipelined transfers are not supported.

Top module: `cdc_mm_bridge`

## Requirements
- R1: Out of reset, and whenever the master asserts neither read nor write, m_wait_o is low and the slave sees neither s_read_o nor s_write_o.
- R2: While the master holds read or write, m_wait_o stays high until the slave side has finished that access. It then goes low for exactly one master cycle, which completes the transfer.
- R3: Each master transfer appears at the slave as either s_read_o or s_write_o, never both. The strobe matches the master's direction (write when m_write_i was high).
- R4: While s_wait_i is high during a slave access, the strobe, s_addr_o and s_wdata_o stay unchanged. The access is accepted at the first slave edge with s_wait_i low.
- R5: s_addr_o and s_wdata_o equal the m_addr_i and m_wdata_i the master presented when it issued the transfer.
- R6: For a read, m_rdata_o in the completion cycle equals s_rdata_i as sampled at the accepting slave edge. m_rdata_o then holds that value through later writes until the next read completes.
- R7: Each master transfer produces exactly one accepted slave access. No access is repeated or dropped.
- R8: A master request issued in the cycle right after a completion, while the handshake is still returning low, is held in wait and is then carried out once with its own address and data.
- R9: Transfers complete correctly both when the slave clock is faster than the master clock and when it is slower.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_clk_i | input | 1 | Master-domain clock |
| m_rst_ni | input | 1 | Master-domain asynchronous reset, active low |
| m_read_i | input | 1 | Master read request |
| m_write_i | input | 1 | Master write request |
| m_addr_i | input | ADDR_W | Master address |
| m_wdata_i | input | DATA_W | Master write data |
| m_rdata_o | output | DATA_W | Read data returned to the master |
| m_wait_o | output | 1 | Stall to the master while its transfer is in flight |
| s_clk_i | input | 1 | Slave-domain clock |
| s_rst_ni | input | 1 | Slave-domain asynchronous reset, active low |
| s_read_o | output | 1 | Read strobe to the slave |
| s_write_o | output | 1 | Write strobe to the slave |
| s_addr_o | output | ADDR_W | Address to the slave |
| s_wdata_o | output | DATA_W | Write data to the slave |
| s_rdata_i | input | DATA_W | Read data from the slave |
| s_wait_i | input | 1 | Slave stall |

## Verification
Two events can share a master cycle. One is the one-cycle release of a finished transfer. The other is a new request from the master, which lands while the acknowledge is still high on its way down. The bench issues every next transfer on the falling edge right after a completion, so the two always meet. It runs this under a fast and a slow slave clock, with stall lengths that vary with the address. It judges the outcome at the slave: exactly one accepted access per master transfer, with that transfer's own address, data and direction, held steady through stalls. Read-back of every written location then confirms the data that returned.

// File: rtl/cdc_mm_pkg.sv
package cdc_mm_pkg;
  typedef enum logic [1:0] {M_IDLE, M_BUSY, M_RELEASE, M_DRAIN} m_state_e;
  typedef enum logic [1:0] {S_IDLE, S_XFER, S_ACK} s_state_e;
endpackage

// File: rtl/cdc_mm_sync.sv
module cdc_mm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;
  logic [N-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[N-2:0], d_i};
  end

  assign q_o = sh_q[N-1];
endmodule

// File: rtl/cdc_mm_master_side.sv
module cdc_mm_master_side
  import cdc_mm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              wait_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  input  logic              ack_async_i,
  input  logic [DATA_W-1:0] hold_rdata_i
);
  m_state_e          state_q;
  logic              ack_s;
  logic              req_q, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  cdc_mm_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_async_i), .q_o(ack_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= M_IDLE;
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        M_IDLE: if (rd_i || wr_i) begin
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          we_q    <= wr_i;
          req_q   <= 1'b1;
          state_q <= M_BUSY;
        end
        M_BUSY: if (ack_s) begin
          // slave hold register is stable while ack is high
          if (!we_q) rdata_q <= hold_rdata_i;
          req_q   <= 1'b0;
          state_q <= M_RELEASE;
        end
        M_RELEASE: state_q <= M_DRAIN;
        M_DRAIN:   if (!ack_s) state_q <= M_IDLE;
        default:   state_q <= M_IDLE;
      endcase
    end
  end

  assign wait_o  = (rd_i || wr_i) && (state_q != M_RELEASE);
  assign rdata_o = rdata_q;
  assign req_o   = req_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign we_o    = we_q;
endmodule

// File: rtl/cdc_mm_slave_side.sv
module cdc_mm_slave_side
  import cdc_mm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_async_i,
  input  logic              we_i,
  output logic              ack_o,
  output logic              read_o,
  output logic              write_o,
  input  logic              wait_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  s_state_e          state_q;
  logic              req_s, ack_q;
  logic [DATA_W-1:0] rdata_q;

  cdc_mm_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(req_async_i), .q_o(req_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_s) state_q <= S_XFER;
        S_XFER: if (!wait_i) begin
          if (!we_i) rdata_q <= rdata_i;
          ack_q   <= 1'b1;
          state_q <= S_ACK;
        end
        S_ACK: if (!req_s) begin
          ack_q   <= 1'b0;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // we_i comes from master-domain registers held stable for the whole request
  assign read_o  = (state_q == S_XFER) && !we_i;
  assign write_o = (state_q == S_XFER) &&  we_i;
  assign ack_o   = ack_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/cdc_mm_bridge.sv
module cdc_mm_bridge #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              m_clk_i,
  input  logic              m_rst_ni,
  input  logic              m_read_i,
  input  logic              m_write_i,
  input  logic [ADDR_W-1:0] m_addr_i,
  input  logic [DATA_W-1:0] m_wdata_i,
  output logic [DATA_W-1:0] m_rdata_o,
  output logic              m_wait_o,
  input  logic              s_clk_i,
  input  logic              s_rst_ni,
  output logic              s_read_o,
  output logic              s_write_o,
  output logic [ADDR_W-1:0] s_addr_o,
  output logic [DATA_W-1:0] s_wdata_o,
  input  logic [DATA_W-1:0] s_rdata_i,
  input  logic              s_wait_i
);
  logic              req_w, ack_w, we_w;
  logic [DATA_W-1:0] hold_rdata_w;

  cdc_mm_master_side #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_mst (
    .clk_i        (m_clk_i),
    .rst_ni       (m_rst_ni),
    .rd_i         (m_read_i),
    .wr_i         (m_write_i),
    .addr_i       (m_addr_i),
    .wdata_i      (m_wdata_i),
    .wait_o       (m_wait_o),
    .rdata_o      (m_rdata_o),
    .req_o        (req_w),
    .addr_o       (s_addr_o),
    .wdata_o      (s_wdata_o),
    .we_o         (we_w),
    .ack_async_i  (ack_w),
    .hold_rdata_i (hold_rdata_w)
  );

  cdc_mm_slave_side #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_slv (
    .clk_i       (s_clk_i),
    .rst_ni      (s_rst_ni),
    .req_async_i (req_w),
    .we_i        (we_w),
    .ack_o       (ack_w),
    .read_o      (s_read_o),
    .write_o     (s_write_o),
    .wait_i      (s_wait_i),
    .rdata_i     (s_rdata_i),
    .rdata_o     (hold_rdata_w)
  );
endmodule

// File: rtl/cdc_mm_bridge_chk.sv
module cdc_mm_bridge_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              m_clk_i,
  input logic              m_rst_ni,
  input logic              s_clk_i,
  input logic              s_rst_ni,
  input logic              m_read_i,
  input logic              m_write_i,
  input logic              m_wait_o,
  input logic              s_read_o,
  input logic              s_write_o,
  input logic              s_wait_i,
  input logic [ADDR_W-1:0] s_addr_o,
  input logic [DATA_W-1:0] s_wdata_o,
  input logic              req_w,
  input logic              ack_w
);
  p_idle_no_wait_r1: assert property (@(posedge m_clk_i) disable iff (!m_rst_ni)
    !(m_read_i || m_write_i) |-> !m_wait_o);

  p_release_after_drop_r2: assert property (@(posedge m_clk_i) disable iff (!m_rst_ni)
    ((m_read_i || m_write_i) && !m_wait_o) |-> !req_w);

  p_one_strobe_r3: assert property (@(posedge s_clk_i) disable iff (!s_rst_ni)
    !(s_read_o && s_write_o));

  p_hold_while_wait_r4: assert property (@(posedge s_clk_i) disable iff (!s_rst_ni)
    ((s_read_o || s_write_o) && s_wait_i) |=>
      ($stable(s_addr_o) && $stable(s_wdata_o) && $stable(s_read_o) && $stable(s_write_o)));

  p_no_strobe_during_ack_r7: assert property (@(posedge s_clk_i) disable iff (!s_rst_ni)
    ack_w |-> !(s_read_o || s_write_o));

  p_ack_needs_req_r8: assert property (@(posedge s_clk_i) disable iff (!s_rst_ni)
    $rose(ack_w) |-> $past(s_read_o || s_write_o));
endmodule

bind cdc_mm_bridge cdc_mm_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .m_clk_i   (m_clk_i),
  .m_rst_ni  (m_rst_ni),
  .s_clk_i   (s_clk_i),
  .s_rst_ni  (s_rst_ni),
  .m_read_i  (m_read_i),
  .m_write_i (m_write_i),
  .m_wait_o  (m_wait_o),
  .s_read_o  (s_read_o),
  .s_write_o (s_write_o),
  .s_wait_i  (s_wait_i),
  .s_addr_o  (s_addr_o),
  .s_wdata_o (s_wdata_o),
  .req_w     (req_w),
  .ack_w     (ack_w)
);

// File: tb/cdc_mm_bridge_tb_top.sv
`timescale 1ns/1ps
module cdc_mm_bridge_tb_top;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NLOC = 1 << AW;

  logic          m_clk = 0, s_clk = 0;
  logic          m_rst_n = 0, s_rst_n = 0;
  logic          m_read = 0, m_write = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wdata = '0;
  logic [DW-1:0] m_rdata;
  logic          m_wait;
  logic          s_read, s_write;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_wdata;
  logic [DW-1:0] s_rdata;
  logic          s_wait = 0;

  int  checks = 0, errors = 0;
  real s_half = 1.7;

  logic [DW-1:0] mem [NLOC];
  logic [DW-1:0] shadow [NLOC];

  // expected transfer seen by the slave model
  logic          exp_we;
  logic [AW-1:0] exp_addr;
  logic [DW-1:0] exp_data;
  int            issued = 0, accepted = 0;

  always #2.5 m_clk = ~m_clk;
  always #(s_half) s_clk = ~s_clk;

  assign s_rdata = mem[s_addr];

  cdc_mm_bridge #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) dut_i (
    .m_clk_i(m_clk), .m_rst_ni(m_rst_n), .m_read_i(m_read), .m_write_i(m_write),
    .m_addr_i(m_addr), .m_wdata_i(m_wdata), .m_rdata_o(m_rdata), .m_wait_o(m_wait),
    .s_clk_i(s_clk), .s_rst_ni(s_rst_n), .s_read_o(s_read), .s_write_o(s_write),
    .s_addr_o(s_addr), .s_wdata_o(s_wdata), .s_rdata_i(s_rdata), .s_wait_i(s_wait)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model: stall length depends on address, checks what it is handed
  bit            in_xfer = 0;
  int            wait_left = 0;
  logic [AW-1:0] l_addr;
  logic [DW-1:0] l_data;
  logic          l_we;
  always @(negedge s_clk) begin
    if (s_read || s_write) begin
      if (!in_xfer) begin
        in_xfer = 1;
        wait_left = int'(s_addr) % 3;
        l_addr = s_addr; l_data = s_wdata; l_we = s_write;
        check(!(s_read && s_write), "R3 single strobe", {30'd0, s_read, s_write}, 32'd1);
        check(s_write == exp_we, "R3 direction", {31'd0, s_write}, {31'd0, exp_we});
        check(s_addr == exp_addr, "R5 address", {28'd0, s_addr}, {28'd0, exp_addr});
        if (exp_we) check(s_wdata == exp_data, "R5 write data", {16'd0, s_wdata}, {16'd0, exp_data});
      end else begin
        check(s_addr == l_addr && s_wdata == l_data && s_write == l_we,
              "R4 held during stall", {16'd0, s_wdata}, {16'd0, l_data});
      end
      if (wait_left > 0) begin
        s_wait = 1;
        wait_left--;
      end else begin
        s_wait = 0;
        accepted++;
        if (s_write) mem[s_addr] = s_wdata;
        in_xfer = 0;
      end
    end else begin
      s_wait = 0;
    end
  end

  // drive at negedge, sample 1 ns later, complete on the posedge with wait low
  task automatic xfer(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      output logic [DW-1:0] rd);
    exp_we = we; exp_addr = a; exp_data = d;
    issued++;
    m_read = !we; m_write = we; m_addr = a; m_wdata = d;
    #1;
    check(m_wait == 1'b1, "R2 wait on issue", {31'd0, m_wait}, 32'd1);
    while (m_wait) begin
      @(negedge m_clk);
      #1;
    end
    rd = m_rdata;
    @(posedge m_clk);
    @(negedge m_clk);
    m_read = 0; m_write = 0;
  endtask

  task automatic run_phase(input int seed);
    logic [DW-1:0] r;
    logic [DW-1:0] held;
    // back-to-back writes: each issued the negedge after the previous completion (R8)
    for (int i = 0; i < NLOC; i++) begin
      logic [DW-1:0] v;
      v = DW'((i * 16'h1357 + seed * 16'h0f1) ^ 16'ha5c3);
      shadow[i] = v;
      xfer(1'b1, AW'(i), v, r);
      m_read = 1'b0; m_write = 1'b0;
    end
    for (int i = NLOC - 1; i >= 0; i--) begin
      xfer(1'b0, AW'(i), DW'(16'hdead), r);
      check(r == shadow[i], "R6 R8 R9 read data", {16'd0, r}, {16'd0, shadow[i]});
    end
    // read then write elsewhere: returned data must hold
    xfer(1'b0, AW'(3), '0, held);
    xfer(1'b1, AW'(5), DW'(16'h0bad), r);
    shadow[5] = DW'(16'h0bad);
    @(negedge m_clk); #1;
    check(m_rdata == held, "R6 hold across write", {16'd0, m_rdata}, {16'd0, held});
    check(m_wait == 1'b0, "R1 idle wait low", {31'd0, m_wait}, 32'd0);
    repeat (20) @(negedge m_clk);
    check(accepted == issued, "R7 one access per transfer", accepted, issued);
  endtask

  initial begin
    for (int i = 0; i < NLOC; i++) mem[i] = '0;
    #1;
    check(m_wait == 1'b0, "R1 reset wait", {31'd0, m_wait}, 32'd0);
    check(!s_read && !s_write, "R1 reset strobes", {30'd0, s_read, s_write}, 32'd0);
    check(m_rdata == '0, "R1 reset rdata", {16'd0, m_rdata}, 32'd0);
    #20;
    @(negedge m_clk); m_rst_n = 1;
    @(negedge s_clk); s_rst_n = 1;
    repeat (4) @(negedge m_clk);
    #1;
    check(m_wait == 1'b0 && !s_read && !s_write, "R1 idle after reset",
          {29'd0, m_wait, s_read, s_write}, 32'd0);
    run_phase(1);          // slave faster (R9)
    s_half = 6.3;
    repeat (10) @(negedge m_clk);
    run_phase(2);          // slave slower (R9)
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge m_clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule